// File: doc/BRIEF.md
# Unserviced-NMI Watchdog Period Counter

This block times how long a non-maskable interrupt stays pending without being serviced. While the NMI-pending input is high, an internal counter advances once per enabled clock. When the count reaches a programmable period, the block sends a single-cycle reset request to the CPU. The counter clears in the same cycle that the request is issued. When the pending input drops, the counter returns to zero.

Software reaches the block through a small register bus. One address holds the 16-bit period, which can be read and written and comes out of reset at all ones. A second address returns the live count for debug and cannot be written.

Lowering the period to a value at or below the count already reached does not wait for a match. It trips the reset request at once and clears the counter. A trip needs the NMI to be pending.

Top module: `nmi_wdog_top`

## Requirements
- R1: After synchronous reset the period reads 0xFFFF, the count reads 0 and `rst_req` is low.
- R2: A write to address 0 loads the period. A read of address 0 returns it on `bus_rdata` one clock after the read is presented.
- R3: A read of address 1 returns the count as it stood in the read cycle. Writes to address 1 change nothing. Addresses 2 and 3 read as 0.
- R4: While `nmi_pend` is high and no trip occurs, the count rises by one on each clock with `clk_en` high and holds on each clock with `clk_en` low.
- R5: On any clock where `nmi_pend` is low, the count returns to 0 and no trip occurs.
- R6: Suppose `nmi_pend` is high and the count equals the period. Then on the next edge `rst_req` goes high and the count becomes 0.
- R7: Suppose a period write carries a value below the present count while `nmi_pend` is high. Then on the next edge `rst_req` goes high, the count becomes 0 and the new period is stored.
- R8: A period write whose value equals the present count, while `nmi_pend` is high, trips in the same way as R7.
- R9: A period write whose value is above the present count does not trip. Counting continues, and a trip occurs when the count reaches the new value.
- R10: With a nonzero period, `rst_req` is high for exactly one clock per trip.
- R11: The count never exceeds the stored period. With period P held, a pending NMI trips once every P+1 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Count enable, qualifies each increment |
| nmi_pend | input | 1 | High while a non-maskable interrupt awaits service |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address (0 period, 1 count) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| rst_req | output | 1 | Registered one-cycle reset request to the CPU |

## Verification
The reset request rises on the first edge after the cycle in which the trip condition holds, whether that condition is a match or a period write. The counter is zero in that same cycle.

Read data appears one edge after the read strobe and holds the count from the cycle of the strobe. The count therefore moves on by one during the read itself.

The stimulus is driven one nanosecond after each rising edge. Direct checks are made at that same point, so they see exactly the edges counted in the test sequence. Read results are queued when the read is issued and popped by a monitor on the falling edge after the capturing edge. The same monitor counts pulses and flags any pulse that lasts two cycles.

// File: rtl/nmi_wdog_pkg.sv
package nmi_wdog_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_PERIOD = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_COUNT  = 2'd1;
endpackage

// File: rtl/nmi_wdog_regs.sv
module nmi_wdog_regs
  import nmi_wdog_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] cnt,
  output logic [DATA_W-1:0] period,
  output logic              per_wr,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam logic [DATA_W-1:0] PERIOD_RST = '1;

  assign per_wr = bus_wr && (bus_addr == ADDR_PERIOD);

  always_ff @(posedge clk) begin
    if (rst)         period <= PERIOD_RST;
    else if (per_wr) period <= bus_wdata;
  end

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    case (bus_addr)
      ADDR_PERIOD: rd_mux = period;
      ADDR_COUNT:  rd_mux = cnt;
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  // R2: a period write lands on the next edge
  a_r2_period_load: assert property (@(posedge clk) disable iff (rst)
    per_wr |=> period == $past(bus_wdata));
  // R3: a write to the count address leaves the period untouched
  a_r3_count_ro: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_COUNT) |=> $stable(period));
endmodule

// File: rtl/nmi_wdog_count.sv
module nmi_wdog_count #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_en,
  input  logic              nmi_pend,
  input  logic              trip,
  output logic [DATA_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || trip || !nmi_pend) cnt <= '0;
    else if (clk_en)              cnt <= cnt + 1'b1;
  end

  // R5: no pending NMI means a zero count next cycle
  a_r5_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !nmi_pend |=> cnt == '0);
  // R4: disabled clocks hold the count
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (nmi_pend && !clk_en && !trip) |=> $stable(cnt));
  // R6: a trip clears the counter
  a_r6_clear: assert property (@(posedge clk) disable iff (rst)
    trip |=> cnt == '0);
endmodule

// File: rtl/nmi_wdog_trip.sv
module nmi_wdog_trip #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              nmi_pend,
  input  logic [DATA_W-1:0] cnt,
  input  logic [DATA_W-1:0] period,
  input  logic              per_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              trip,
  output logic              rst_req
);
  logic [DATA_W-1:0] eff_period;

  // A period write is compared against the count in its own cycle:
  // equal is a match, below is a forced trip.
  assign eff_period = per_wr ? wdata : period;
  assign trip       = nmi_pend && (cnt >= eff_period);

  always_ff @(posedge clk) begin
    if (rst) rst_req <= 1'b0;
    else     rst_req <= trip;
  end

  // R6: every trip produces the request on the next edge
  a_r6_pulse: assert property (@(posedge clk) disable iff (rst)
    trip |=> rst_req);
  // R5: no request without a pending NMI in the cycle before
  a_r5_needs_nmi: assert property (@(posedge clk) disable iff (rst)
    !nmi_pend |=> !rst_req);
  // R10: one-cycle pulse while the period stays nonzero
  a_r10_single: assert property (@(posedge clk) disable iff (rst)
    (rst_req && period != '0 && !(per_wr && wdata == '0)) |=> !rst_req);
endmodule

// File: rtl/nmi_wdog_top.sv
module nmi_wdog_top
  import nmi_wdog_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_en,
  input  logic              nmi_pend,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              rst_req
);
  logic [DATA_W-1:0] cnt;
  logic [DATA_W-1:0] period;
  logic              per_wr;
  logic              trip;

  nmi_wdog_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cnt(cnt),
    .period(period), .per_wr(per_wr), .bus_rdata(bus_rdata)
  );

  nmi_wdog_trip #(.DATA_W(DATA_W)) u_trip (
    .clk(clk), .rst(rst), .nmi_pend(nmi_pend), .cnt(cnt),
    .period(period), .per_wr(per_wr), .wdata(bus_wdata),
    .trip(trip), .rst_req(rst_req)
  );

  nmi_wdog_count #(.DATA_W(DATA_W)) u_count (
    .clk(clk), .rst(rst), .clk_en(clk_en), .nmi_pend(nmi_pend),
    .trip(trip), .cnt(cnt)
  );

  // R11: the counter never passes the stored period
  a_r11_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= period);
  // R7: a request always finds the counter already cleared
  a_r7_req_clear: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> cnt == '0);
endmodule

// File: tb/test_nmi_wdog_top.sv
`timescale 1ns/1ps
module test_nmi_wdog_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clk_en = 1'b0;
  logic        nmi_pend = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        rst_req;

  nmi_wdog_top i_nmi_wdog_top (
    .clk(clk), .rst(rst), .clk_en(clk_en), .nmi_pend(nmi_pend),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_req(rst_req)
  );

  always #2 clk = ~clk;

  typedef struct {
    logic [15:0] val;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  int   pulses = 0;
  int   p0;
  logic rd_pend = 1'b0;
  logic req_prev = 1'b0;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops queued read expectations, counts pulses
  always @(negedge clk) begin
    if (rd_pend) begin
      if (q.size() == 0) chk("queue", 16'h1, 16'h0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk(e.tag, bus_rdata, e.val);
      end
    end
    rd_pend = bus_rd && !rst;
    if (!rst && rst_req) begin
      pulses++;
      chk("R10 single-cycle pulse", {15'd0, req_prev}, 16'h0);
    end
    req_prev = rst_req && !rst;
  end

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic rd(input logic [1:0] a, input logic [15:0] exp, input string tag);
    bus_rd = 1'b1;
    bus_addr = a;
    q.push_back('{exp, tag});
    step(1);
    bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    bus_wr = 1'b1;
    bus_addr = a;
    bus_wdata = d;
    step(1);
    bus_wr = 1'b0;
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    step(3);
    rst = 1'b0;
    // R1 reset state
    chk("R1 rst_req", {15'd0, rst_req}, 16'h0);
    rd(2'd0, 16'hFFFF, "R1 period");
    rd(2'd1, 16'h0000, "R1 count");

    // R2 period read/write
    wr(2'd0, 16'h1234);
    rd(2'd0, 16'h1234, "R2 period readback");

    // R3 count not writable, spare addresses read zero
    wr(2'd1, 16'h0055);
    rd(2'd1, 16'h0000, "R3 count after write");
    rd(2'd2, 16'h0000, "R3 spare addr");

    // R4 counting and hold
    wr(2'd0, 16'd100);
    nmi_pend = 1'b1;
    clk_en = 1'b1;
    step(10);
    rd(2'd1, 16'd10, "R4 count");
    clk_en = 1'b0;
    step(5);
    rd(2'd1, 16'd11, "R4 hold");

    // R5 idle clears
    clk_en = 1'b1;
    nmi_pend = 1'b0;
    step(3);
    rd(2'd1, 16'd0, "R5 idle zero");

    // R6 match trip
    wr(2'd0, 16'd5);
    nmi_pend = 1'b1;
    step(5);
    chk("R6 before match", {15'd0, rst_req}, 16'h0);
    step(1);
    chk("R6 trip", {15'd0, rst_req}, 16'h1);
    rd(2'd1, 16'd0, "R6 count cleared");
    chk("R10 pulse ends", {15'd0, rst_req}, 16'h0);
    nmi_pend = 1'b0;
    step(1);

    // R7 forced trip on lowered period
    wr(2'd0, 16'hFFFF);
    nmi_pend = 1'b1;
    step(20);
    wr(2'd0, 16'd7);
    chk("R7 forced trip", {15'd0, rst_req}, 16'h1);
    rd(2'd1, 16'd0, "R7 count cleared");
    nmi_pend = 1'b0;
    rd(2'd0, 16'd7, "R7 period stored");

    // R8 equal write trips
    wr(2'd0, 16'hFFFF);
    nmi_pend = 1'b1;
    step(9);
    wr(2'd0, 16'd9);
    chk("R8 equal trip", {15'd0, rst_req}, 16'h1);
    nmi_pend = 1'b0;
    step(1);

    // R9 raised period keeps counting
    wr(2'd0, 16'hFFFF);
    nmi_pend = 1'b1;
    step(9);
    wr(2'd0, 16'd12);
    chk("R9 no trip on write", {15'd0, rst_req}, 16'h0);
    step(2);
    chk("R9 no trip at 12", {15'd0, rst_req}, 16'h0);
    step(1);
    chk("R9 trip at new period", {15'd0, rst_req}, 16'h1);
    nmi_pend = 1'b0;
    step(1);

    // R3 write to count while pending
    wr(2'd0, 16'hFFFF);
    nmi_pend = 1'b1;
    step(4);
    wr(2'd1, 16'h0000);
    rd(2'd1, 16'd5, "R3 count unaffected");
    rd(2'd3, 16'h0000, "R3 spare addr 3");
    nmi_pend = 1'b0;
    step(1);

    // R11 periodic trips, one per P+1 clocks
    wr(2'd0, 16'd3);
    p0 = pulses;
    nmi_pend = 1'b1;
    step(40);
    nmi_pend = 1'b0;
    step(1);
    chk("R11 trip count", 16'(pulses - p0), 16'd10);
    rd(2'd1, 16'd0, "R11 count idle");

    step(3);
    finish_run();
  end
endmodule